// File: doc/BRIEF.md
# Region-Based Memory Access Filter

This block sits beside a memory transaction path and rules on each access: it compares the access address with a bank of programmable address windows and returns allow or deny together with the number of the window that decided. Each window has a page-aligned base, an inclusive page-aligned top, a two-bit permission used for secure accesses, a bitmap of the filter ports on which it takes part, and a 32-bit mask that grants reads and writes to individual non-secure requester IDs.

Window 0 is a background window. It covers the whole address space on every filter port, and software can change only its permission and its ID mask. Windows 1 and up are fully programmable. When no programmable window claims an address the background window decides. When two or more claim it, the access is denied and an overlap flag is raised. Configuration goes through a plain single-cycle write port with a combinational read-back. Every address register is split into a low and a high 32-bit word. The decision is registered, one cycle after the access is presented.

Top module: `region_access_filter`

## Requirements
- R1: Window 0 matches every address on every filter port. Its base reads back as 0, its top as all ones (up to ADDR_W bits), and its filter bitmap as all ones. Writes to its base, top and bitmap fields have no effect.
- R2: The permission and ID mask of window 0 are writable, and they decide any access that no programmable window claims.
- R3: Addresses have 4 KB granularity. Base low words read back with bits [11:0] equal to 0, and top low words read back with bits [11:0] equal to 0xFFF, whatever value was written to those bits.
- R4: A programmable window claims an address A only when base <= A <= top. The top address is inclusive, and top+1 falls outside the window.
- R5: A programmable window takes part only for filter ports whose bit is set in its bitmap, which is attribute bits [NF-1:0], with bit 0 for port 0.
- R6: A secure access uses the permission in attribute bits [31:30]. 0 allows nothing, 1 allows reads only, 2 allows writes only, 3 allows both.
- R7: A non-secure access ignores the permission. A read with requester ID i is allowed only if mask bit i is set, and a write only if mask bit 16+i is set.
- R8: When two or more programmable windows claim an access, the access is denied, the overlap output is 1, and the reported window is the lowest-numbered claimant.
- R9: With exactly one programmable claimant, that window is reported and decides the access. With none, window 0 is reported and overlap is 0.
- R10: The outputs dec_valid, dec_allow, dec_region and dec_overlap are registered. They reflect the access presented at the previous rising clock edge, with dec_valid equal to the previous acc_valid. The configuration in force before that same edge is used.
- R11: Configuration addressing: cfg_addr[6:3] selects the window and cfg_addr[2:0] the word. The words are 0 base low, 1 base high, 2 top low, 3 top high, 4 attribute, 5 ID mask. High words hold ADDR_W-32 bits and the remaining bits read 0. Writes to windows at or above NR have no effect and read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Window number [6:3], word select [2:0] |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read-back of the addressed word |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_nonsec | input | 1 | 1 for a non-secure access |
| acc_id | input | 4 | Requester ID of the access |
| acc_filter | input | 2 | Filter port that carries the access |
| dec_valid | output | 1 | Decision present |
| dec_allow | output | 1 | Access allowed |
| dec_region | output | 4 | Window that decided |
| dec_overlap | output | 1 | Two or more programmable windows claimed the access |

## Verification
The matching logic is tried with addresses one page either side of each base and top, and on the exact boundaries, so an exclusive top or an off-by-one page compare shows up. The same addresses are sent on two filter ports to separate the bitmap from the range check. Secure and non-secure accesses of both directions and with several IDs distinguish the permission path from the mask path. Two windows that partly overlap are set up so that the overlap rule, the lowest-claimant report and the background fallback all give different outcomes at nearby addresses. A long random stream then runs against a behavioural model.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
  localparam int ID_W   = 4;
  localparam int MASK_W = 2 * (1 << ID_W);
  localparam int PERM_LSB = 30;

  localparam logic [2:0] W_BASE_LO = 3'd0;
  localparam logic [2:0] W_BASE_HI = 3'd1;
  localparam logic [2:0] W_TOP_LO  = 3'd2;
  localparam logic [2:0] W_TOP_HI  = 3'd3;
  localparam logic [2:0] W_ATTR    = 3'd4;
  localparam logic [2:0] W_MASK    = 3'd5;

  // Secure check: bit 0 grants reads, bit 1 grants writes.
  function automatic logic sec_permits(logic [1:0] perm, logic is_write);
    return is_write ? perm[1] : perm[0];
  endfunction

  // Non-secure check: read grants in the lower half, write grants in the upper half.
  function automatic logic id_permits(logic [MASK_W-1:0] mask,
                                      logic [ID_W-1:0] id, logic is_write);
    return mask[{is_write, id}];
  endfunction
endpackage

// File: rtl/rmf_region_regs.sv
module rmf_region_regs
  import rmf_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int NF     = 4,
  parameter bit BG     = 1'b0,
  localparam int PW    = ADDR_W - 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        word,
  input  logic [31:0]       wdata,
  output logic [PW-1:0]     base_pg,
  output logic [PW-1:0]     top_pg,
  output logic [1:0]        perm,
  output logic [NF-1:0]     fen,
  output logic [MASK_W-1:0] idmask,
  output logic [31:0]       rdata
);
  logic [1:0]        perm_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q <= '0;
      mask_q <= '0;
    end else if (we) begin
      if (word == W_ATTR) perm_q <= wdata[PERM_LSB +: 2];
      if (word == W_MASK) mask_q <= wdata[MASK_W-1:0];
    end
  end

  generate
    if (BG) begin : g_fixed
      assign base_pg = '0;
      assign top_pg  = '1;
      assign fen     = '1;
    end else begin : g_prog
      logic [PW-1:0] base_q, top_q;
      logic [NF-1:0] fen_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          base_q <= '0;
          top_q  <= '0;
          fen_q  <= '0;
        end else if (we) begin
          case (word)
            W_BASE_LO: base_q[19:0]    <= wdata[31:12];
            W_BASE_HI: base_q[PW-1:20] <= wdata[PW-21:0];
            W_TOP_LO:  top_q[19:0]     <= wdata[31:12];
            W_TOP_HI:  top_q[PW-1:20]  <= wdata[PW-21:0];
            W_ATTR:    fen_q           <= wdata[NF-1:0];
            default: ;
          endcase
        end
      end
      assign base_pg = base_q;
      assign top_pg  = top_q;
      assign fen     = fen_q;
    end
  endgenerate

  assign perm   = perm_q;
  assign idmask = mask_q;

  always_comb begin
    rdata = '0;
    case (word)
      W_BASE_LO: rdata = {base_pg[19:0], 12'h000};
      W_BASE_HI: rdata[PW-21:0] = base_pg[PW-1:20];
      W_TOP_LO:  rdata = {top_pg[19:0], 12'hFFF};
      W_TOP_HI:  rdata[PW-21:0] = top_pg[PW-1:20];
      W_ATTR: begin
        rdata[PERM_LSB +: 2] = perm_q;
        rdata[NF-1:0]        = fen;
      end
      W_MASK:    rdata[MASK_W-1:0] = mask_q;
      default:   rdata = '0;
    endcase
  end

  // R6: an attribute write lands in the permission field one cycle later
  assert_perm_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && word == W_ATTR) |=> (perm == $past(wdata[PERM_LSB +: 2])));
endmodule

// File: rtl/rmf_region_match.sv
module rmf_region_match #(
  parameter int PW = 28,
  parameter int NF = 4,
  localparam int FW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic [PW-1:0] pg,
  input  logic [FW-1:0] filt,
  input  logic [PW-1:0] base_pg,
  input  logic [PW-1:0] top_pg,
  input  logic [NF-1:0] fen,
  output logic          hit
);
  logic in_range, on_port;
  assign in_range = (pg >= base_pg) && (pg <= top_pg);
  assign on_port  = fen[filt];
  assign hit      = in_range && on_port;
endmodule

// File: rtl/rmf_decide.sv
module rmf_decide
  import rmf_pkg::*;
#(
  parameter int NR = 9,
  localparam int RW = $clog2(NR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic               acc_nonsec,
  input  logic [ID_W-1:0]    acc_id,
  input  logic [NR-1:0]      hits,
  input  logic [NR*2-1:0]    perm_flat,
  input  logic [NR*MASK_W-1:0] mask_flat,
  output logic               dec_valid,
  output logic               dec_allow,
  output logic [RW-1:0]      dec_region,
  output logic               dec_overlap
);
  logic [RW-1:0] sel_c;
  logic          ovl_c, prog_none, allow_c;
  int            claim_cnt;

  always_comb begin
    sel_c = '0;
    for (int r = NR - 1; r >= 1; r--) begin
      if (hits[r]) sel_c = RW'(r);
    end
  end

  assign claim_cnt = $countones(hits[NR-1:1]);
  assign ovl_c     = claim_cnt > 1;
  assign prog_none = claim_cnt == 0;

  always_comb begin
    if (ovl_c)
      allow_c = 1'b0;
    else if (acc_nonsec)
      allow_c = id_permits(mask_flat[sel_c*MASK_W +: MASK_W], acc_id, acc_write);
    else
      allow_c = sec_permits(perm_flat[sel_c*2 +: 2], acc_write);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_allow   <= 1'b0;
      dec_region  <= '0;
      dec_overlap <= 1'b0;
    end else begin
      dec_valid   <= acc_valid;
      dec_allow   <= acc_valid && allow_c;
      dec_region  <= sel_c;
      dec_overlap <= acc_valid && ovl_c;
    end
  end

  // R8: several programmable claimants deny the access
  assert_ovl_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && ovl_c) |=> (dec_overlap && !dec_allow));
  // R9: no programmable claimant falls back to window 0
  assert_bg_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && prog_none) |=> (dec_region == '0 && !dec_overlap));
  // R9: the reported window is always implemented
  assert_region_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (int'(dec_region) < NR));
  // R10: one-cycle latency of the valid flag
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> dec_valid);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !dec_valid);
endmodule

// File: rtl/region_access_filter.sv
module region_access_filter
  import rmf_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int NR     = 9,
  parameter int NF     = 4,
  localparam int RW    = $clog2(NR),
  localparam int FW    = (NF > 1) ? $clog2(NF) : 1,
  localparam int PW    = ADDR_W - 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RW+2:0]     cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              acc_nonsec,
  input  logic [ID_W-1:0]   acc_id,
  input  logic [FW-1:0]     acc_filter,
  output logic              dec_valid,
  output logic              dec_allow,
  output logic [RW-1:0]     dec_region,
  output logic              dec_overlap
);
  logic [RW-1:0]         sel_reg;
  logic [2:0]            sel_word;
  logic [PW-1:0]         acc_pg;
  logic [NR-1:0]         hits;
  logic [NR*2-1:0]       perm_flat;
  logic [NR*MASK_W-1:0]  mask_flat;
  logic [31:0]           rd_arr [NR];

  assign sel_reg  = cfg_addr[RW+2:3];
  assign sel_word = cfg_addr[2:0];
  assign acc_pg   = acc_addr[ADDR_W-1:12];

  generate
    for (genvar r = 0; r < NR; r++) begin : g_win
      logic [PW-1:0]     b_pg, t_pg;
      logic [1:0]        pm;
      logic [NF-1:0]     fe;
      logic [MASK_W-1:0] im;
      logic              wr_hit;

      assign wr_hit = cfg_we && (sel_reg == RW'(r));

      rmf_region_regs #(.ADDR_W(ADDR_W), .NF(NF), .BG(r == 0)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(wr_hit), .word(sel_word),
        .wdata(cfg_wdata), .base_pg(b_pg), .top_pg(t_pg), .perm(pm),
        .fen(fe), .idmask(im), .rdata(rd_arr[r])
      );

      rmf_region_match #(.PW(PW), .NF(NF)) u_match (
        .pg(acc_pg), .filt(acc_filter), .base_pg(b_pg), .top_pg(t_pg),
        .fen(fe), .hit(hits[r])
      );

      assign perm_flat[r*2 +: 2]           = pm;
      assign mask_flat[r*MASK_W +: MASK_W] = im;
    end
  endgenerate

  always_comb begin
    cfg_rdata = '0;
    for (int r = 0; r < NR; r++) begin
      if (sel_reg == RW'(r)) cfg_rdata = rd_arr[r];
    end
  end

  rmf_decide #(.NR(NR)) u_decide (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_nonsec(acc_nonsec), .acc_id(acc_id), .hits(hits),
    .perm_flat(perm_flat), .mask_flat(mask_flat), .dec_valid(dec_valid),
    .dec_allow(dec_allow), .dec_region(dec_region), .dec_overlap(dec_overlap)
  );

  // R1: the background window claims every access
  assert_bg_claims_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> hits[0]);
endmodule

// File: tb/sim_region_access_filter.sv
module sim_region_access_filter;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        acc_valid = 0, acc_write = 0, acc_nonsec = 0;
  logic [39:0] acc_addr = '0;
  logic [3:0]  acc_id = '0;
  logic [1:0]  acc_filter = '0;
  logic        dec_valid, dec_allow, dec_overlap;
  logic [3:0]  dec_region;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  region_access_filter u0 (.*);

  // behavioural model
  logic [63:0] mb [9];
  logic [63:0] mt [9];
  logic [1:0]  mp [9];
  logic [3:0]  mf [9];
  logic [31:0] mm [9];
  logic        ev_valid, ev_allow, ev_ovl;
  int          ev_region;

  initial begin
    for (int r = 0; r < 9; r++) begin
      mb[r] = 0; mt[r] = 64'hFFF; mp[r] = 0; mf[r] = 0; mm[r] = 0;
    end
    ev_valid = 0; ev_allow = 0; ev_ovl = 0; ev_region = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      ev_valid = 0; ev_allow = 0; ev_ovl = 0; ev_region = 0;
    end else begin
      int cnt; int sel; logic [63:0] a;
      cnt = 0; sel = 0; a = {24'h0, acc_addr};
      for (int r = 1; r < 9; r++)
        if (mf[r][acc_filter] && a >= mb[r] && a <= mt[r]) begin
          if (cnt == 0) sel = r;
          cnt++;
        end
      ev_valid  = acc_valid;
      ev_region = sel;
      ev_ovl    = acc_valid && cnt > 1;
      if (!acc_valid || cnt > 1) ev_allow = 0;
      else if (acc_nonsec) ev_allow = mm[sel][acc_id + (acc_write ? 16 : 0)];
      else ev_allow = acc_write ? mp[sel][1] : mp[sel][0];
      if (cfg_we && cfg_addr[6:3] < 9) begin
        int r; r = cfg_addr[6:3];
        case (cfg_addr[2:0])
          0: if (r != 0) mb[r][31:0] = cfg_wdata & 32'hFFFFF000;
          1: if (r != 0) mb[r][63:32] = cfg_wdata & 32'hFF;
          2: if (r != 0) mt[r][31:0] = cfg_wdata | 32'hFFF;
          3: if (r != 0) mt[r][63:32] = cfg_wdata & 32'hFF;
          4: begin mp[r] = cfg_wdata[31:30]; if (r != 0) mf[r] = cfg_wdata[3:0]; end
          5: mm[r] = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (dec_valid !== ev_valid) begin
        errors++;
        $display("FAIL R10 model dec_valid=%0b exp=%0b", dec_valid, ev_valid);
      end else if (ev_valid && (dec_overlap !== ev_ovl)) begin
        errors++;
        $display("FAIL R8 model overlap=%0b exp=%0b", dec_overlap, ev_ovl);
      end else if (ev_valid && (int'(dec_region) != ev_region)) begin
        errors++;
        $display("FAIL R9 model region=%0d exp=%0d", dec_region, ev_region);
      end else if (ev_valid && (dec_allow !== ev_allow)) begin
        errors++;
        $display("FAIL %s model allow=%0b exp=%0b", acc_nonsec ? "R7" : "R6",
                 dec_allow, ev_allow);
      end
    end
  end

  task automatic wr(input int r, input int w, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 7'((r << 3) | w); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd_chk(input int r, input int w, input logic [31:0] exp,
                        input string tag);
    cfg_addr = 7'((r << 3) | w);
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read win %0d word %0d: got %h exp %h", tag, r, w, cfg_rdata, exp);
    end
  endtask

  task automatic acc(input logic [39:0] a, input bit w, input bit ns,
                     input int id, input int f, input bit e_allow,
                     input int e_reg, input bit e_ovl, input string tag);
    acc_valid = 1; acc_addr = a; acc_write = w; acc_nonsec = ns;
    acc_id = 4'(id); acc_filter = 2'(f);
    @(negedge clk);
    acc_valid = 0;
    checks++;
    if (dec_allow !== e_allow || int'(dec_region) != e_reg || dec_overlap !== e_ovl) begin
      errors++;
      $display("FAIL %s addr %h: allow=%0b region=%0d ovl=%0b exp allow=%0b region=%0d ovl=%0b",
               tag, a, dec_allow, dec_region, dec_overlap, e_allow, e_reg, e_ovl);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (dec_valid !== 0 || dec_allow !== 0) begin
      errors++;
      $display("FAIL R10 reset outputs valid=%0b allow=%0b exp 0 0", dec_valid, dec_allow);
    end
    rst_n = 1;
    @(negedge clk);

    // R1 background window read-back and write protection
    rd_chk(0, 0, 32'h0, "R1");
    rd_chk(0, 2, 32'hFFFFFFFF, "R1");
    rd_chk(0, 3, 32'h000000FF, "R1");
    rd_chk(0, 4, 32'h0000000F, "R1");
    wr(0, 0, 32'h5000_0000);
    wr(0, 3, 32'h0);
    rd_chk(0, 0, 32'h0, "R1");
    rd_chk(0, 3, 32'h000000FF, "R1");
    // R2 permission of window 0 decides, initially none
    acc(40'h00_1234_5000, 0, 0, 0, 2, 0, 0, 0, "R2");
    wr(0, 4, 32'hC000_0000);
    rd_chk(0, 4, 32'hC000_000F, "R1");
    acc(40'hFF_FFFF_FFFF, 1, 0, 0, 3, 1, 0, 0, "R1");

    // window 1: RO, filter 0, id5 read only
    wr(1, 0, 32'h1000_0ABC);
    wr(1, 2, 32'h1FFF_F000);
    wr(1, 4, 32'h4000_0001);
    wr(1, 5, 32'h0000_0020);
    rd_chk(1, 0, 32'h1000_0000, "R3");
    rd_chk(1, 2, 32'h1FFF_FFFF, "R3");
    rd_chk(1, 6, 32'h0, "R11");
    acc(40'h00_1000_0000, 0, 0, 0, 0, 1, 1, 0, "R4");
    acc(40'h00_1000_0000, 1, 0, 0, 0, 0, 1, 0, "R6");
    acc(40'h00_0FFF_FFFF, 1, 0, 0, 0, 1, 0, 0, "R4");
    acc(40'h00_1FFF_FFFF, 1, 0, 0, 0, 0, 1, 0, "R4");
    acc(40'h00_2000_0000, 1, 0, 0, 0, 1, 0, 0, "R4");
    acc(40'h00_1500_0000, 1, 0, 0, 1, 1, 0, 0, "R5");
    acc(40'h00_1500_0000, 0, 1, 5, 0, 1, 1, 0, "R7");
    acc(40'h00_1500_0000, 1, 1, 5, 0, 0, 1, 0, "R7");
    acc(40'h00_1500_0000, 0, 1, 3, 0, 0, 1, 0, "R7");
    // window 0 mask used for non-secure fallback
    wr(0, 5, 32'h0008_0000);
    acc(40'h00_3000_0000, 1, 1, 3, 0, 1, 0, 0, "R2");
    acc(40'h00_3000_0000, 0, 1, 3, 0, 0, 0, 0, "R7");

    // window 2: WO, filters 0 and 1, overlapping window 1
    wr(2, 0, 32'h1800_0000);
    wr(2, 2, 32'h2700_0000);
    wr(2, 4, 32'h8000_0003);
    rd_chk(2, 2, 32'h2700_0FFF, "R3");
    acc(40'h00_1800_0000, 0, 0, 0, 0, 0, 1, 1, "R8");
    acc(40'h00_17FF_FFFF, 0, 0, 0, 0, 1, 1, 0, "R9");
    acc(40'h00_1800_0000, 1, 0, 0, 1, 1, 2, 0, "R9");
    acc(40'h00_2000_0000, 0, 0, 0, 0, 0, 2, 0, "R6");

    // window 3: one page above 4 GB
    wr(3, 1, 32'hFFFF_FF12);
    wr(3, 0, 32'h0000_0ABC);
    wr(3, 3, 32'h12);
    wr(3, 2, 32'h0);
    wr(3, 4, 32'hC000_0004);
    rd_chk(3, 1, 32'h12, "R11");
    rd_chk(3, 0, 32'h0, "R3");
    wr(9, 4, 32'hFFFF_FFFF);
    rd_chk(9, 4, 32'h0, "R11");
    acc(40'h12_0000_0FFF, 1, 0, 0, 2, 1, 3, 0, "R4");
    acc(40'h12_0000_1000, 1, 0, 0, 2, 1, 0, 0, "R4");
    acc(40'h02_0000_0000, 1, 0, 0, 2, 1, 0, 0, "R4");

    // random stream near the window edges, checked by the model
    for (int i = 0; i < 600; i++) begin
      int k; k = $urandom_range(0, 11);
      case (k)
        0: acc_addr = 40'h00_0FFF_FFFF;  1: acc_addr = 40'h00_1000_0000;
        2: acc_addr = 40'h00_17FF_FFFF;  3: acc_addr = 40'h00_1800_0000;
        4: acc_addr = 40'h00_1FFF_FFFF;  5: acc_addr = 40'h00_2000_0000;
        6: acc_addr = 40'h00_2700_0FFF;  7: acc_addr = 40'h00_2700_1000;
        8: acc_addr = 40'h12_0000_0000;  9: acc_addr = 40'h12_0000_1000;
        default: acc_addr = {$urandom_range(0, 255), $urandom()};
      endcase
      acc_valid  = ($urandom_range(0, 4) != 0);
      acc_write  = 1'($urandom());
      acc_nonsec = 1'($urandom());
      acc_id     = 4'($urandom());
      acc_filter = 2'($urandom());
      if (i == 300) begin
        cfg_we = 1; cfg_addr = 7'((1 << 3) | 5); cfg_wdata = $urandom();
      end else cfg_we = 0;
      @(negedge clk);
    end
    acc_valid = 0; cfg_we = 0;
    repeat (2) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule